// File: doc/BRIEF.md
# I2C Master Status and Interrupt-Enable Unit

This unit sits beside the byte engine of an I2C master. It keeps two byte-wide registers. The status register latches three events reported by the engine as one-cycle strobes: a wait at the ninth clock, a missing acknowledge, and lost arbitration. The same register shows live copies of the bus-busy flag, the SCL and SDA line levels, and a data-empty flag. The data-empty flag follows the transmit data register state and is never latched. Software clears a latched event by writing 0 to its bit. Writing 1 to a bit leaves it as it is.

The interrupt-enable register holds one enable for each event and two DMA request enables. Its top two bits carry bit 8 of the SCL low and high count values, which are passed on to the clock generator. A single interrupt line goes high when any latched event has its enable set. Data-empty also raises the interrupt, unless transmit DMA is enabled; in that case it drives a transmit DMA request instead. With receive DMA enabled, each received byte sets a receive DMA request. A read of the data register offset clears that request. While the wait event is latched, the unit tells the engine to hold SCL low.

Reads are combinational. `rdata` is zero when no read is strobed or the offset is not hosted here, so it can be ORed into a wider register read mux.

Top module: `i2c_stat_unit`

## Requirements
- R1: After reset the three latched events, the interrupt-enable register, `irq`, `tx_dma_req`, `rx_dma_req`, `scl_hold` and `cnt_ext` are all 0.
- R2: A read of the status offset 0x08 returns bit 7 = SCL level, bit 6 = SDA level, bit 5 = 0, bit 4 = busy, bit 3 = arbitration lost, bit 2 = ack fail, bit 1 = wait, bit 0 = data empty. The live bits (7, 6, 4, 0) show the current input values.
- R3: A one-cycle strobe on `ev_arb_lost`, `ev_nack` or `ev_wait` sets status bit 3, 2 or 1 at the next clock edge. The bit then stays set until software clears it.
- R4: A write to offset 0x08 clears each latched event whose write bit is 0 and keeps each whose write bit is 1. Bits 7, 6, 4 and 0 are not affected by such a write.
- R5: If an event strobe arrives in the same cycle as a write that clears that event, the event ends up set.
- R6: Offset 0x0C reads back the last 8-bit value written to it. Bit 5 is the transmit DMA enable, bit 4 the receive DMA enable, bits 3..0 the enables for arbitration lost, ack fail, wait and data empty, and `cnt_ext` equals bits 7..6.
- R7: `irq` is high exactly when at least one latched event has its enable set, or when data empty is high with its enable (bit 0) set and transmit DMA (bit 5) clear.
- R8: `tx_dma_req` is high exactly when data empty is high and transmit DMA is enabled.
- R9: With receive DMA enabled, an `rx_done` strobe sets `rx_dma_req` at the next edge. A read strobe at offset 0x00 clears it; if the strobe and the read fall in the same cycle, set wins. `rx_done` has no effect while receive DMA is disabled.
- R10: `scl_hold` is high exactly while the wait event is latched.
- R11: `rdata` is 0 when `rd_en` is low or when the offset is neither 0x08 nor 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| ev_wait | input | 1 | Engine strobe: ninth-clock wait reached |
| ev_nack | input | 1 | Engine strobe: acknowledge missing |
| ev_arb_lost | input | 1 | Engine strobe: arbitration lost |
| rx_done | input | 1 | Engine strobe: byte received |
| dr_empty | input | 1 | Level: transmit data register empty |
| bus_busy | input | 1 | Level: bus between START and STOP |
| scl_level | input | 1 | Sampled SCL line level |
| sda_level | input | 1 | Sampled SDA line level |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| scl_hold | output | 1 | Hold SCL low after the eighth bit |
| cnt_ext | output | 2 | Bit 8 of SCL low count (1) and high count (0) |

## Verification
The live status bits are swept over all sixteen combinations, which shows the bit positions are not swapped. Every latched event pattern is crossed with all 256 status write values, which separates write-zero-clears from write-one-clears and shows the live bits ignore writes. The interrupt and transmit DMA outputs are swept over every event pattern, the low six enable bits and both data-empty levels, which exposes a missing enable, a wrong mask bit or a data-empty path that fails to yield to DMA. The same-cycle collisions (strobe with clear, `rx_done` with data read) show whether set has priority over clear.

// File: rtl/i2c_stat_unit.sv
module i2c_stat_unit #(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFS = 'h00,
  parameter int STAT_OFS = 'h08,
  parameter int IEN_OFS  = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              ev_wait,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic              rx_done,
  input  logic              dr_empty,
  input  logic              bus_busy,
  input  logic              scl_level,
  input  logic              sda_level,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              scl_hold,
  output logic [1:0]        cnt_ext
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);
  localparam int B_TXDMA = 5;
  localparam int B_RXDMA = 4;

  logic [2:0] ev_q;
  logic [7:0] ien_q;
  logic       rx_q;

  wire stat_wr = wr_en && addr == A_STAT;
  wire ien_wr  = wr_en && addr == A_IEN;
  wire data_rd = rd_en && addr == A_DATA;

  wire [2:0] keep_mask = stat_wr ? wdata[3:1] : 3'b111;
  wire [2:0] ev_in     = {ev_arb_lost, ev_nack, ev_wait};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      ien_q <= '0;
      rx_q  <= 1'b0;
    end else begin
      ev_q <= (ev_q & keep_mask) | ev_in;
      if (ien_wr) ien_q <= wdata;
      rx_q <= (rx_q && !data_rd) || (rx_done && ien_q[B_RXDMA]);
    end
  end

  wire [7:0] stat_view = {scl_level, sda_level, 1'b0, bus_busy, ev_q, dr_empty};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_STAT) rdata = stat_view;
      else if (addr == A_IEN) rdata = ien_q;
    end
  end

  wire dte_irq = dr_empty && ien_q[0] && !ien_q[B_TXDMA];

  assign irq        = |(ev_q & ien_q[3:1]) || dte_irq;
  assign tx_dma_req = dr_empty && ien_q[B_TXDMA];
  assign rx_dma_req = rx_q;
  assign scl_hold   = ev_q[0];
  assign cnt_ext    = ien_q[7:6];

endmodule

module i2c_stat_unit_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFS = 'h00,
  parameter int STAT_OFS = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic              ev_wait,
  input logic              ev_nack,
  input logic              ev_arb_lost,
  input logic              rx_done,
  input logic              dr_empty,
  input logic [2:0]        ev_q,
  input logic [7:0]        ien_q,
  input logic              irq,
  input logic              tx_dma_req,
  input logic              rx_dma_req,
  input logic              scl_hold
);

  wire swr = wr_en && addr == ADDR_W'(STAT_OFS);
  wire drd = rd_en && addr == ADDR_W'(DATA_OFS);

  assert_event_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[2] && !(swr && !wdata[3]) |=> ev_q[2]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost || ev_nack || ev_wait |=> ev_q != 3'b000);

  assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swr && !wdata[2] && !ev_nack |=> !ev_q[1]);

  assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[0] && ien_q[1] |-> irq);

  assert_txdma_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> dr_empty);

  assert_rx_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drd && !rx_done |=> !rx_dma_req);

  assert_hold_follows_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[0] |-> scl_hold);

endmodule

bind i2c_stat_unit i2c_stat_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .ev_wait(ev_wait), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost),
  .rx_done(rx_done), .dr_empty(dr_empty), .ev_q(ev_q), .ien_q(ien_q), .irq(irq),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .scl_hold(scl_hold)
);

// File: tb/test_i2c_stat_unit.sv
module test_i2c_stat_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_wait = 0, ev_nack = 0, ev_arb_lost = 0, rx_done = 0;
  logic       dr_empty = 0, bus_busy = 0, scl_level = 0, sda_level = 0;
  logic       irq, tx_dma_req, rx_dma_req, scl_hold;
  logic [1:0] cnt_ext;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  i2c_stat_unit i_i2c_stat_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ev_wait(ev_wait), .ev_nack(ev_nack),
    .ev_arb_lost(ev_arb_lost), .rx_done(rx_done), .dr_empty(dr_empty),
    .bus_busy(bus_busy), .scl_level(scl_level), .sda_level(sda_level),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .scl_hold(scl_hold), .cnt_ext(cnt_ext)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1ns d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk);
    {ev_arb_lost, ev_nack, ev_wait} = p;
    @(negedge clk);
    {ev_arb_lost, ev_nack, ev_wait} = 3'b000;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h08, r); check("R1 status", r, 8'h00);
    rd(8'h0C, r); check("R1 ien", r, 8'h00);
    check("R1 outs", {3'b0, irq, tx_dma_req, rx_dma_req, cnt_ext}, 8'h00);
    check("R1 hold", {7'b0, scl_hold}, 8'h00);

    // R2 live bit positions
    for (int i = 0; i < 16; i++) begin
      {scl_level, sda_level, bus_busy, dr_empty} = 4'(i);
      rd(8'h08, r);
      check("R2 live", r, {i[3], i[2], 1'b0, i[1], 3'b000, i[0]});
    end
    {scl_level, sda_level, bus_busy, dr_empty} = 4'b1011;

    // R6 enable register readback and count extension
    for (int v = 0; v < 256; v++) begin
      wr(8'h0C, 8'(v));
      rd(8'h0C, r); check("R6 ien", r, 8'(v));
      check("R6 ext", {6'b0, cnt_ext}, {6'b0, 2'(v >> 6)});
    end
    wr(8'h0C, 8'h00);

    // R3/R4 latch and write-zero clear, live bits unaffected
    for (int p = 0; p < 8; p++) begin
      for (int w = 0; w < 256; w++) begin
        pulse(3'(p));
        rd(8'h08, r); check("R3 latch", r, {4'b1001, 3'(p), 1'b1});
        wr(8'h08, 8'(w));
        rd(8'h08, r); check("R4 clear", r, {4'b1001, 3'(p) & 3'(w >> 1), 1'b1});
        wr(8'h08, 8'h00);
      end
    end

    // R5 set wins over clear
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      addr = 8'h08; wdata = 8'h00; wr_en = 1'b1;
      {ev_arb_lost, ev_nack, ev_wait} = 3'(1 << b);
      @(negedge clk);
      wr_en = 1'b0; {ev_arb_lost, ev_nack, ev_wait} = 3'b000;
      rd(8'h08, r); check("R5 collide", {5'b0, r[3:1]}, 8'(1 << b));
      wr(8'h08, 8'h00);
    end

    // R7/R8/R10 interrupt, tx dma and hold sweep
    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 64; e++)
        for (int d = 0; d < 2; d++) begin
          logic exp_irq;
          wr(8'h08, 8'h00);
          pulse(3'(p));
          wr(8'h0C, 8'(e));
          dr_empty = d[0];
          @(negedge clk); #1ns;
          exp_irq = ((p & (e >> 1) & 7) != 0) || (d == 1 && e[0] && !e[5]);
          check("R7 irq", {7'b0, irq}, {7'b0, exp_irq});
          check("R8 txdma", {7'b0, tx_dma_req}, {7'b0, d[0] & e[5]});
          check("R10 hold", {7'b0, scl_hold}, {7'b0, p[0]});
        end
    wr(8'h08, 8'h00);
    wr(8'h0C, 8'h00);

    // R9 receive DMA request
    @(negedge clk); rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    check("R9 disabled", {7'b0, rx_dma_req}, 8'h00);
    wr(8'h0C, 8'h10);
    @(negedge clk); rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    check("R9 set", {7'b0, rx_dma_req}, 8'h01);
    rd(8'h08, r);
    check("R9 other read", {7'b0, rx_dma_req}, 8'h01);
    rd(8'h00, r);
    check("R9 data read", {7'b0, rx_dma_req}, 8'h00);
    @(negedge clk); addr = 8'h00; rd_en = 1'b1; rx_done = 1'b1;
    @(negedge clk); rd_en = 1'b0; rx_done = 1'b0;
    check("R9 collide", {7'b0, rx_dma_req}, 8'h01);

    // R11 unmapped offsets and idle read
    wr(8'h0C, 8'hFF);
    pulse(3'b111);
    rd(8'h00, r); check("R11 data ofs", r, 8'h00);
    rd(8'h04, r); check("R11 ctrl ofs", r, 8'h00);
    rd(8'h10, r); check("R11 other ofs", r, 8'h00);
    @(negedge clk); addr = 8'h08; #1ns;
    check("R11 no rd", rdata, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule